// File: doc/BRIEF.md
# Open-Row SDRAM Command Sequencer

This block sits between a simple request port and an SDRAM device. It turns each accepted read or write request into the command sequence the device needs. It drives the active-low command strobes, the bank select, the shared row/column address bus and the write data bus. It remembers the open row in each of the four banks. A request that lands in an open row goes straight to the column command. A request that misses first closes the bank's row if one is open, then activates the new row. Three configuration inputs set the precharge-to-activate gap, the activate-to-column gap and the CAS latency.

Requests arrive on a valid/ready port. The host holds `req_valid` and every request field stable until it sees `req_ready` high at a clock edge. `req_ready` is high only while the sequencer can issue a column command in the next cycle. It drops during precharge and activate gaps and while a read is waiting out its latency, and this is the only back-pressure. Read data leaves on `rsp_valid`/`rsp_data` for one cycle and cannot be stalled.

The `req_seq` transfer-type flag marks a request as the next beat of an incrementing burst. The block then builds the address itself from the previous beat. This covers single accesses, fixed-length bursts and bursts of open length. A burst that runs off the end of a page falls into a new bank or row and is handled as a miss.

Top module: `sdram_seq`

## Requirements
- R1: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as: no-op 0111, activate 0011, read 0101, write 0100, precharge 0010. A cycle that issues no command shows the no-op code.
- R2: During and after reset the outputs show no-op, `req_ready`=1, `rsp_valid`=0 and `sd_dq_oe`=0, and every bank is closed. The first access to any bank therefore activates without a precharge.
- R3: A request accepted at edge k whose bank already holds its row puts the read or write command on the bus in the cycle after edge k, with no precharge or activate.
- R4: A request to a closed bank issues activate in the cycle after acceptance, then exactly `cfg_trcd` no-op cycles, then the column command.
- R5: A request to a bank whose open row differs issues precharge (address 0, so only that bank closes), then exactly `cfg_trp` no-op cycles, then activate, then `cfg_trcd` no-op cycles, then the column command.
- R6: The request address splits into column (bits COL_W-1:0), bank (the next BANK_W bits) and row (the upper ROW_W bits). `sd_ba` carries the bank on every command. `sd_addr` carries the row during activate and the column, zero-extended, during read and write.
- R7: Read data is sampled from `sd_dq_in` at the edge that ends the cycle `cfg_cl` (1 to 3) cycles after the read command cycle. It is shown on `rsp_data` with `rsp_valid`=1 for the next cycle. `req_ready` stays low from the read command cycle until that cycle.
- R8: `sd_dq_oe` is high exactly in write command cycles, and `sd_dq_out` then carries the request's data.
- R9: When `req_seq`=1 the request address is the previous accepted address plus one, and `req_addr` is ignored. Back-to-back writes to an open row issue one write per clock.
- R10: A sequential beat whose incremented address leaves the current page (a new bank or row) is handled as a miss by R4 or R5 before its column command.
- R11: A request is taken only at an edge where `req_valid` and `req_ready` are both high. A request held while `req_ready` is low is taken later and not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trp | input | TIMER_W | No-op cycles between precharge and activate |
| cfg_trcd | input | TIMER_W | No-op cycles between activate and column command |
| cfg_cl | input | 2 | CAS latency, 1 to 3 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_seq | input | 1 | 1 = next beat of an incrementing burst |
| req_addr | input | COL_W+BANK_W+ROW_W | Word address (ignored when req_seq=1) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_data | output | DATA_W | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ROW_W | Row/column address bus |
| sd_dq_out | output | DATA_W | Write data to device |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dq_in | input | DATA_W | Read data from device |

## Verification
The stimulus mixes requests that land in open rows, in closed banks and in banks holding another row. Each class must produce a different command train: column only, activate first, or precharge then activate. Incrementing bursts are run both inside a page and across a page end, which separates in-page streaming at one write per clock from the miss inserted at the crossing. The gap and latency settings are changed between phases, including zero gaps and latencies 1, 2 and 3. Throughout, the device model drives valid read data in one cycle only, so a latency counted one cycle early or late returns a wrong word.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRP,
    ST_TRCD,
    ST_RDW
  } seq_state_e;
endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)            count <= '0;
    else if (load)         count <= load_val;
    else if (count != '0)  count <= count - 1'b1;
  end

  assign zero = (count == '0);

  // Once expired and not reloaded, the timer must stay expired (gap counting, R4)
  assert_timer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count == '0) |=> count == '0);
endmodule

// File: rtl/sdram_row_table.sv
module sdram_row_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_en,
  input  logic              close_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [BANK_W-1:0] rd_bank,
  output logic              rd_open,
  output logic [ROW_W-1:0]  rd_row,
  output logic [(1<<BANK_W)-1:0] open_vec
);
  localparam int BANKS = 1 << BANK_W;

  logic [ROW_W-1:0] row_arr [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             valid_q;
    logic [ROW_W-1:0] row_q;
    logic             sel;

    assign sel = (wr_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        row_q   <= '0;
      end else if (open_en && sel) begin
        valid_q <= 1'b1;
        row_q   <= wr_row;
      end else if (close_en && sel) begin
        valid_q <= 1'b0;
      end
    end

    assign open_vec[b] = valid_q;
    assign row_arr[b]  = row_q;
  end

  assign rd_open = open_vec[rd_bank];
  assign rd_row  = row_arr[rd_bank];

  // A row may only be activated in a bank that holds no open row (R4, R5)
  assert_act_on_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |-> !open_vec[wr_bank]);
endmodule

// File: rtl/sdram_addr_gen.sv
module sdram_addr_gen #(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic                          seq,
  input  logic [COL_W+BANK_W+ROW_W-1:0] addr_in,
  output logic [COL_W+BANK_W+ROW_W-1:0] eff,
  output logic [COL_W-1:0]              col,
  output logic [BANK_W-1:0]             bank,
  output logic [ROW_W-1:0]              row
);
  localparam int AW = COL_W + BANK_W + ROW_W;

  logic [AW-1:0] next_q;

  assign eff  = seq ? next_q : addr_in;
  assign col  = eff[COL_W-1:0];
  assign bank = eff[COL_W +: BANK_W];
  assign row  = eff[AW-1 -: ROW_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    next_q <= '0;
    else if (take) next_q <= eff + 1'b1;
  end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int DATA_W  = 32,
  parameter int TIMER_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TIMER_W-1:0]            cfg_trp,
  input  logic [TIMER_W-1:0]            cfg_trcd,
  input  logic [1:0]                    cfg_cl,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic                          req_seq,
  input  logic [COL_W+BANK_W+ROW_W-1:0] req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_data,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DATA_W-1:0]             sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DATA_W-1:0]             sd_dq_in
);
  localparam int AW    = COL_W + BANK_W + ROW_W;
  localparam int BANKS = 1 << BANK_W;

  seq_state_e state_q, state_d;
  sd_cmd_e    cmd_q, cmd_d;

  logic              hs;
  logic [AW-1:0]     ag_eff;
  logic [COL_W-1:0]  ag_col;
  logic [BANK_W-1:0] ag_bank;
  logic [ROW_W-1:0]  ag_row;

  logic              pend_we;
  logic [COL_W-1:0]  pend_col;
  logic [BANK_W-1:0] pend_bank;
  logic [ROW_W-1:0]  pend_row;
  logic [DATA_W-1:0] pend_data;

  logic              cur_we;
  logic [COL_W-1:0]  cur_col;
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;
  logic [DATA_W-1:0] cur_data;

  logic              tbl_open, tbl_close, tbl_rd_open;
  logic [ROW_W-1:0]  tbl_rd_row;
  logic [BANKS-1:0]  open_vec;

  logic               tmr_load, tmr_zero;
  logic [TIMER_W-1:0] tmr_val, tmr_count;
  logic               capture;

  logic [ROW_W-1:0]   addr_d;
  logic [BANK_W-1:0]  ba_q;
  logic [ROW_W-1:0]   addr_q;
  logic [DATA_W-1:0]  dq_q;
  logic               oe_q;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;

  assign req_ready = (state_q == ST_IDLE);
  assign hs        = req_valid && req_ready;

  sdram_addr_gen #(.COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (hs),
    .seq     (req_seq),
    .addr_in (req_addr),
    .eff     (ag_eff),
    .col     (ag_col),
    .bank    (ag_bank),
    .row     (ag_row)
  );

  // Current access context: live request in idle, latched request otherwise
  always_comb begin
    if (state_q == ST_IDLE) begin
      cur_we   = req_write;
      cur_col  = ag_col;
      cur_bank = ag_bank;
      cur_row  = ag_row;
      cur_data = req_wdata;
    end else begin
      cur_we   = pend_we;
      cur_col  = pend_col;
      cur_bank = pend_bank;
      cur_row  = pend_row;
      cur_data = pend_data;
    end
  end

  sdram_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .open_en  (tbl_open),
    .close_en (tbl_close),
    .wr_bank  (cur_bank),
    .wr_row   (cur_row),
    .rd_bank  (cur_bank),
    .rd_open  (tbl_rd_open),
    .rd_row   (tbl_rd_row),
    .open_vec (open_vec)
  );

  sdram_gap_timer #(.W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_count),
    .zero     (tmr_zero)
  );

  // Sequencing decisions
  always_comb begin
    logic col_go;
    logic act_go;
    state_d   = state_q;
    cmd_d     = CMD_NOP;
    addr_d    = addr_q;
    tbl_open  = 1'b0;
    tbl_close = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    capture   = 1'b0;
    col_go    = 1'b0;
    act_go    = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (hs) begin
          if (tbl_rd_open && tbl_rd_row == cur_row) begin
            col_go = 1'b1;
          end else if (tbl_rd_open) begin
            cmd_d     = CMD_PRE;
            addr_d    = '0;
            tbl_close = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = cfg_trp;
            state_d   = ST_TRP;
          end else begin
            act_go = 1'b1;
          end
        end
      end
      ST_TRP:  if (tmr_zero) act_go = 1'b1;
      ST_TRCD: if (tmr_zero) col_go = 1'b1;
      ST_RDW: begin
        if (tmr_zero) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (act_go) begin
      cmd_d    = CMD_ACT;
      addr_d   = cur_row;
      tbl_open = 1'b1;
      tmr_load = 1'b1;
      tmr_val  = cfg_trcd;
      state_d  = ST_TRCD;
    end

    if (col_go) begin
      addr_d = ROW_W'(cur_col);
      if (cur_we) begin
        cmd_d   = CMD_WR;
        state_d = ST_IDLE;
      end else begin
        cmd_d    = CMD_RD;
        tmr_load = 1'b1;
        tmr_val  = TIMER_W'(cfg_cl);
        state_d  = ST_RDW;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cmd_q       <= CMD_NOP;
      ba_q        <= '0;
      addr_q      <= '0;
      dq_q        <= '0;
      oe_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      pend_we     <= 1'b0;
      pend_col    <= '0;
      pend_bank   <= '0;
      pend_row    <= '0;
      pend_data   <= '0;
    end else begin
      state_q     <= state_d;
      cmd_q       <= cmd_d;
      addr_q      <= addr_d;
      oe_q        <= (cmd_d == CMD_WR);
      rsp_valid_q <= capture;
      if (cmd_d != CMD_NOP) ba_q <= cur_bank;
      if (cmd_d == CMD_WR)  dq_q <= cur_data;
      if (capture)          rsp_data_q <= sd_dq_in;
      if (hs) begin
        pend_we   <= req_write;
        pend_col  <= ag_col;
        pend_bank <= ag_bank;
        pend_row  <= ag_row;
        pend_data <= req_wdata;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  // Column commands only go to a bank holding an open row (R3)
  assert_col_open_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> open_vec[sd_ba]);

  // Precharge is followed by a no-op or an activate, never a column command (R5)
  assert_pre_then_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |=> (cmd_q == CMD_NOP || cmd_q == CMD_ACT));

  // Non-zero precharge gap puts a no-op right after precharge (R5)
  assert_pre_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE && cfg_trp != '0) |=> (cmd_q == CMD_NOP));

  // Non-zero activate gap puts a no-op right after activate (R4)
  assert_act_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_ACT && cfg_trcd != '0) |=> (cmd_q == CMD_NOP));

  // The host is held off while a read waits for its data (R7)
  assert_read_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD) |-> !req_ready);

  // Data bus is driven only with a write command (R8)
  assert_oe_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd_q == CMD_WR));
endmodule

// File: tb/sdram_seq_test.sv
module sdram_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 9;
  localparam int BANK_W = 2;
  localparam int ROW_W = 13;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int AW = COL_W + BANK_W + ROW_W;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] cfg_trp, cfg_trcd;
  logic [1:0] cfg_cl;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_seq = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [BANK_W-1:0] sd_ba;
  logic [ROW_W-1:0] sd_addr;
  logic [DW-1:0] sd_dq_out;
  logic sd_dq_oe;
  logic [DW-1:0] sd_dq_in = '0;

  sdram_seq #(.COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .DATA_W(DW), .TIMER_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_cl(cfg_cl),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_seq(req_seq),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0]  cmd;
    int          ba;
    int          a;
    bit          chk_a;
    bit          oe;
    logic [31:0] d;
    bit          rdy;
    bit          rv;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit bopen[4];
  int brow[4];
  logic [31:0] mem_h[int];
  logic [31:0] mem_d[int];
  int nxt = 0, prev_eff = -1;
  int drow[4];
  int dcnt = 0;
  logic [31:0] ddata = '0;
  bit hs_p = 0, l_w = 0, l_s = 0;
  int l_a = 0;
  logic [31:0] l_d = '0;

  function automatic exp_t mk(logic [3:0] c, int ba, int a, bit chk, bit oe, logic [31:0] d,
                              bit rdy, bit rv, logic [31:0] rd, string tag);
    exp_t e;
    e.cmd = c; e.ba = ba; e.a = a; e.chk_a = chk; e.oe = oe; e.d = d;
    e.rdy = rdy; e.rv = rv; e.rd = rd; e.tag = tag;
    return e;
  endfunction

  function automatic void check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  // Reference model: expand one accepted request into per-cycle expectations
  function automatic void accept(bit w, bit s, int a, logic [31:0] d);
    int eff, col, bank, row;
    string tag;
    eff  = s ? nxt : a;
    nxt  = (eff + 1) % (1 << AW);
    col  = eff % (1 << COL_W);
    bank = (eff >> COL_W) % 4;
    row  = eff >> (COL_W + BANK_W);
    if (!s) tag = "R3";
    else if (prev_eff >= 0 && (prev_eff >> COL_W) != (eff >> COL_W)) tag = "R10";
    else tag = "R9";
    prev_eff = eff;
    if (!(bopen[bank] && brow[bank] == row)) begin
      if (bopen[bank]) begin
        q.push_back(mk(C_PRE, bank, 0, 1, 0, 0, 0, 0, 0, "R5"));
        for (int i = 0; i < int'(cfg_trp); i++) q.push_back(mk(C_NOP, 0, 0, 0, 0, 0, 0, 0, 0, "R5"));
      end
      q.push_back(mk(C_ACT, bank, row, 1, 0, 0, 0, 0, 0, "R4"));
      for (int i = 0; i < int'(cfg_trcd); i++) q.push_back(mk(C_NOP, 0, 0, 0, 0, 0, 0, 0, 0, "R4"));
      bopen[bank] = 1;
      brow[bank] = row;
    end
    if (w) begin
      mem_h[eff] = d;
      q.push_back(mk(C_WR, bank, col, 1, 1, d, 1, 0, 0, tag));
    end else begin
      q.push_back(mk(C_RD, bank, col, 1, 0, 0, 0, 0, 0, tag));
      for (int i = 0; i < int'(cfg_cl); i++) q.push_back(mk(C_NOP, 0, 0, 0, 0, 0, 0, 0, 0, "R7"));
      q.push_back(mk(C_NOP, 0, 0, 0, 0, 0, 1, 1, mem_h.exists(eff) ? mem_h[eff] : 32'h0, "R7"));
    end
  endfunction

  always @(negedge clk) begin
    exp_t e;
    logic [3:0] cmd;
    int key;
    if (rst_n) begin
      if (hs_p) accept(l_w, l_s, l_a, l_d);
      if (q.size() != 0) e = q.pop_front();
      else e = mk(C_NOP, 0, 0, 0, 0, 0, 1, 0, 0, "R1");
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      check(cmd == e.cmd, e.tag, "command code", cmd, e.cmd);
      if (e.chk_a) begin
        check(int'(sd_ba) == e.ba, "R6", "bank", sd_ba, e.ba);
        check(int'(sd_addr) == e.a, "R6", "address", sd_addr, e.a);
      end
      check(sd_dq_oe == e.oe, "R8", "dq_oe", sd_dq_oe, e.oe);
      if (e.oe) check(sd_dq_out == e.d, "R8", "write data", sd_dq_out, e.d);
      check(req_ready == e.rdy, "R11", "req_ready", req_ready, e.rdy);
      check(rsp_valid == e.rv, "R7", "rsp_valid", rsp_valid, e.rv);
      if (e.rv) check(rsp_data == e.rd, "R7", "rsp_data", rsp_data, e.rd);
      // Device model: returns stored data only in the cycle CL after the read
      key = (int'(sd_ba) << (ROW_W + COL_W)) | (drow[sd_ba] << COL_W) | (int'(sd_addr) % (1 << COL_W));
      if (dcnt > 0) begin
        dcnt--;
        sd_dq_in = (dcnt == 0) ? ddata : (32'hBAD00000 ^ 32'(cyc));
      end else sd_dq_in = 32'hBAD00000 ^ 32'(cyc);
      if (cmd == C_ACT) drow[sd_ba] = int'(sd_addr);
      if (cmd == C_WR) mem_d[key] = sd_dq_out;
      if (cmd == C_RD) begin
        ddata = mem_d.exists(key) ? mem_d[key] : 32'h0;
        dcnt = int'(cfg_cl);
      end
      hs_p = req_valid && req_ready;
      l_w = req_write; l_s = req_seq; l_a = int'(req_addr); l_d = req_wdata;
    end else begin
      hs_p = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R11 watchdog actual=%0d expected<=100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int mkaddr(int row, int bank, int col);
    return (row << (COL_W + BANK_W)) | (bank << COL_W) | col;
  endfunction

  task automatic req(bit w, bit s, int a, logic [31:0] d);
    req_valid = 1; req_write = w; req_seq = s; req_addr = a[AW-1:0]; req_wdata = d;
    do begin @(negedge clk); #1; end while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #2; end while (q.size() != 0 || hs_p);
    repeat (2) begin @(posedge clk); #1; end
  endtask

  task automatic set_cfg(int trp, int trcd, int cl);
    cfg_trp = TW'(trp); cfg_trcd = TW'(trcd); cfg_cl = 2'(cl);
  endtask

  initial begin
    set_cfg(2, 3, 2);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 R2: reset state
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R2", "reset command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    check(req_ready == 1'b1, "R2", "reset req_ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R2", "reset rsp_valid", rsp_valid, 0);
    check(sd_dq_oe == 1'b0, "R2", "reset dq_oe", sd_dq_oe, 0);
    @(posedge clk); #1;
    rst_n = 1;

    // Closed bank (R2 R4), then an in-page write burst (R9)
    req(1, 0, mkaddr(0, 0, 16), 32'h1000_0010);
    req(1, 1, 0, 32'h1000_0011);
    req(1, 1, 0, 32'h1000_0012);
    req(1, 1, 0, 32'h1000_0013);
    // Hit read (R3 R7), held while waiting (R11)
    req(0, 0, mkaddr(0, 0, 16), 0);
    req(0, 0, mkaddr(0, 0, 18), 0);
    // Row conflict in bank 0 (R5)
    req(1, 0, mkaddr(5, 0, 32), 32'h2000_0020);
    req(0, 0, mkaddr(0, 0, 17), 0);
    req(0, 0, mkaddr(5, 0, 32), 0);
    // Burst across a page end (R10)
    req(1, 0, mkaddr(2, 1, 510), 32'h3000_01FE);
    req(1, 1, 0, 32'h3000_01FF);
    req(1, 1, 0, 32'h3000_0200);
    req(1, 1, 0, 32'h3000_0201);
    req(0, 0, mkaddr(2, 1, 511), 0);
    req(0, 0, mkaddr(2, 2, 0), 0);
    wait_idle();

    // Zero gaps, latency 1
    set_cfg(0, 0, 1);
    req(1, 0, mkaddr(7, 3, 5), 32'h4000_0005);
    req(1, 0, mkaddr(8, 3, 6), 32'h4000_0006);
    req(0, 0, mkaddr(7, 3, 5), 0);
    req(0, 1, 0, 0);
    req(0, 0, mkaddr(8, 3, 6), 0);
    wait_idle();

    // Latency 3, mixed gaps, sequential reads across a page end
    set_cfg(1, 3, 3);
    req(0, 0, mkaddr(0, 0, 16), 0);
    req(0, 1, 0, 0);
    req(0, 0, mkaddr(2, 1, 510), 0);
    req(0, 1, 0, 0);
    req(0, 1, 0, 0);
    req(1, 0, mkaddr(9, 2, 1), 32'h5000_0001);
    req(0, 0, mkaddr(9, 2, 1), 0);
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule